// File: doc/BRIEF.md
# Memory-Mapped I/O Interconnect with Bit-Per-Word LED and Switch Registers

This block sits behind the uncached path of a processor and serves every request whose address falls in the top 64 KiB of the address space (0xFFFF0000 to 0xFFFFFFFF). A requester raises a read or write strobe together with an address and write data and holds all of them until it sees a one-cycle `done` pulse. The interconnect decodes the address to one device, forwards the request to that device, and routes exactly that device's `done` and read data back.

Two devices live inside the block: a bank of LED outputs and a bank of switch inputs. Each LED or switch bit is a register of its own at a word address, four bytes apart. Two further regions are served outside the block: a read-only boot ROM in the top 8 KiB and a 32-byte UART window. Each has a select output and its own `done` and read data inputs. External devices take the request strobes, address and write data straight from the requester's lines.

A three-state controller does the sequencing. In ST_IDLE the block decodes the address. It takes the IDLE_TO_LOCAL transition for LED, switch, unmapped or ROM-write requests, and the IDLE_TO_EXT transition for ROM reads and UART accesses. It stays in IDLE when no request is present or the address is outside the window. From ST_LOCAL it always returns to IDLE (LOCAL_TO_IDLE) after answering. ST_EXT holds the device select (EXT_WAIT) until that device's done arrives, then returns to IDLE (EXT_TO_IDLE).

Top module: `mmio_hub`

## Requirements
- R1: A request whose address is outside 0xFFFF0000..0xFFFFFFFF gets no response: `rsp_done` stays 0, `rsp_rdata` stays 0 and neither select output is raised, however long the request is held.
- R2: `rsp_done` is high for exactly one cycle per accepted request, and `rsp_rdata` is zero in every cycle where `rsp_done` is low.
- R3: A write to 0xFFFF0100 + 4*n (n = 0..23, excluding addresses claimed by the UART window) sets `led_out[n]` to bit 0 of the write data. The new value is visible in the cycle `rsp_done` is high, one cycle after the request is first presented. A write returns read data 0.
- R4: A read of LED n returns the current `led_out[n]` in bit 0, with bits 31..1 zero, and `done` comes one cycle after the request.
- R5: A read of 0xFFFF0000 + 4*n (n = 0..23) returns `sw_in[n]`, sampled in the cycle the request is accepted, in bit 0 with the upper bits zero, and `done` comes one cycle after the request.
- R6: A write to a switch address completes with `done` after one cycle and changes nothing: `led_out` keeps its value.
- R7: A request to an address inside the window that no device claims (for example switch or LED index 24 and up, or 0xFFFF0200) completes with `done` one cycle after the request and read data 0. `led_out` does not change.
- R8: A read in 0xFFFFE000..0xFFFFFFFF raises `rom_sel` from the cycle after acceptance until `rom_done`. `rsp_done` and `rsp_rdata` then follow `rom_done` and `rom_rdata` in that same cycle.
- R9: An access in 0xFFFF0120..0xFFFF013F goes to the UART through `uart_sel` in the same way as R8, and has priority over the LED addresses it overlaps: such a write leaves `led_out` unchanged.
- R10: A write into the boot ROM region is not forwarded: `rom_sel` stays 0 and the write completes locally with `done` after one cycle and read data 0.
- R11: After reset, `led_out` is 0, `rsp_done` is 0 and both selects are 0.
- R12: At most one select is high at a time, and a `done` from a device that is not selected is not routed to `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_rd | input | 1 | Read request, held until done |
| req_wr | input | 1 | Write request, held until done |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with rsp_done |
| sw_in | input | 24 | Switch input levels |
| led_out | output | 24 | LED register outputs |
| rom_sel | output | 1 | Boot ROM selected |
| rom_done | input | 1 | Boot ROM completion |
| rom_rdata | input | 32 | Boot ROM read data |
| uart_sel | output | 1 | UART window selected |
| uart_done | input | 1 | UART completion |
| uart_rdata | input | 32 | UART read data |

## Verification
The assertions assume the requester follows the handshake: it raises only one of `req_rd` and `req_wr`, and it holds address, data and strobe steady until it sees `rsp_done`, then drops them. They also assume an external device raises its `done` for a single cycle. The bench drives requests at the falling edge and keeps them until the response has been sampled. Its ROM and UART models answer with one-cycle pulses after a chosen delay. A stray `done` from the unselected device is injected only to exercise the routing rule, and that device is never selected at the time.

// File: rtl/mmio_hub_pkg.sv
package mmio_hub_pkg;

    // Device selected by the address decoder, in no particular order.
    typedef enum logic [2:0] {
        DEV_NONE,   // outside the I/O window
        DEV_HOLE,   // inside the window, nobody claims it
        DEV_SW,
        DEV_LED,
        DEV_UART,
        DEV_ROM
    } dev_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOCAL,
        ST_EXT
    } hub_state_e;

    localparam logic [15:0] WINDOW_HI = 16'hFFFF;

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_hub_pkg::*;
#(
    parameter int N_BITS    = 24,
    parameter int SW_OFF    = 'h0000,
    parameter int LED_OFF   = 'h0100,
    parameter int UART_OFF  = 'h0120,
    parameter int UART_SPAN = 32,
    parameter int ROM_OFF   = 'hE000,
    localparam int IDX_W    = $clog2(N_BITS)
) (
    input  logic [31:0]      addr,
    input  logic             is_wr,
    output dev_e             dev,
    output logic [IDX_W-1:0] idx
);

    localparam int SW_END   = SW_OFF + 4 * N_BITS;
    localparam int LED_END  = LED_OFF + 4 * N_BITS;
    localparam int UART_END = UART_OFF + UART_SPAN;

    logic        in_win;
    int unsigned off;
    logic        hit_rom, hit_uart, hit_led, hit_sw;

    always_comb begin
        in_win   = (addr[31:16] == WINDOW_HI);
        off      = int'(addr[15:0]);
        hit_rom  = off >= ROM_OFF;
        hit_uart = (off >= UART_OFF) && (off < UART_END);
        hit_led  = (off >= LED_OFF) && (off < LED_END);
        hit_sw   = (off >= SW_OFF) && (off < SW_END);
    end

    // Priority: ROM, then UART, then LED, then switch, then hole.
    always_comb begin
        dev = DEV_NONE;
        idx = '0;
        if (in_win) begin
            if (hit_rom) begin
                dev = is_wr ? DEV_HOLE : DEV_ROM;
            end else if (hit_uart) begin
                dev = DEV_UART;
            end else if (hit_led) begin
                dev = DEV_LED;
                idx = IDX_W'((off - LED_OFF) >> 2);
            end else if (hit_sw) begin
                dev = DEV_SW;
                idx = IDX_W'((off - SW_OFF) >> 2);
            end else begin
                dev = DEV_HOLE;
            end
        end
    end

    always_comb begin
        if (dev == DEV_LED || dev == DEV_SW) begin
            a_idx_range_r7: assert (int'(idx) < N_BITS);
        end
    end

endmodule

// File: rtl/mmio_bitbank.sv
module mmio_bitbank #(
    parameter int N_BITS = 24,
    localparam int IDX_W = $clog2(N_BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              led_we,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wbit,
    input  logic              sel_led,
    input  logic [N_BITS-1:0] sw_in,
    output logic [N_BITS-1:0] led_out,
    output logic              rd_bit
);

    logic [N_BITS-1:0] led_q;

    // One flop per LED, each with its own decoded write strobe.
    for (genvar g = 0; g < N_BITS; g++) begin : g_led
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                led_q[g] <= 1'b0;
            end else if (led_we && idx == IDX_W'(g)) begin
                led_q[g] <= wbit;
            end
        end
    end

    always_comb begin
        rd_bit = 1'b0;
        for (int i = 0; i < N_BITS; i++) begin
            if (idx == IDX_W'(i)) begin
                rd_bit = sel_led ? led_q[i] : sw_in[i];
            end
        end
    end

    assign led_out = led_q;

    p_led_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !led_we |=> $stable(led_out));

    p_led_only_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        led_we |=> $countones(led_out ^ $past(led_out)) <= 1);

endmodule

// File: rtl/mmio_hub.sv
module mmio_hub
    import mmio_hub_pkg::*;
#(
    parameter int N_BITS    = 24,
    parameter int SW_OFF    = 'h0000,
    parameter int LED_OFF   = 'h0100,
    parameter int UART_OFF  = 'h0120,
    parameter int UART_SPAN = 32,
    parameter int ROM_OFF   = 'hE000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_done,
    output logic [31:0]       rsp_rdata,
    input  logic [N_BITS-1:0] sw_in,
    output logic [N_BITS-1:0] led_out,
    output logic              rom_sel,
    input  logic              rom_done,
    input  logic [31:0]       rom_rdata,
    output logic              uart_sel,
    input  logic              uart_done,
    input  logic [31:0]       uart_rdata
);

    localparam int IDX_W = $clog2(N_BITS);

    hub_state_e       state_q, state_d;
    dev_e             dev_now, dev_q;
    logic [IDX_W-1:0] idx_now;
    logic             rd_bit_now, bit_q;
    logic             req_any, accept, to_ext, led_we, ext_done;

    mmio_decode #(
        .N_BITS(N_BITS), .SW_OFF(SW_OFF), .LED_OFF(LED_OFF),
        .UART_OFF(UART_OFF), .UART_SPAN(UART_SPAN), .ROM_OFF(ROM_OFF)
    ) u_decode (
        .addr  (req_addr),
        .is_wr (req_wr),
        .dev   (dev_now),
        .idx   (idx_now)
    );

    assign req_any = req_rd | req_wr;
    assign accept  = (state_q == ST_IDLE) && req_any && (dev_now != DEV_NONE);
    assign to_ext  = (dev_now == DEV_ROM) || (dev_now == DEV_UART);
    assign led_we  = accept && req_wr && (dev_now == DEV_LED);

    mmio_bitbank #(.N_BITS(N_BITS)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .led_we  (led_we),
        .idx     (idx_now),
        .wbit    (req_wdata[0]),
        .sel_led (dev_now == DEV_LED),
        .sw_in   (sw_in),
        .led_out (led_out),
        .rd_bit  (rd_bit_now)
    );

    assign ext_done = (dev_q == DEV_ROM  && rom_done) ||
                      (dev_q == DEV_UART && uart_done);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = to_ext ? ST_EXT : ST_LOCAL;
                end
            end
            ST_LOCAL: state_d = ST_IDLE;
            ST_EXT: begin
                if (ext_done) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register plus the facts latched at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dev_q   <= DEV_NONE;
            bit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                dev_q <= dev_now;
                bit_q <= !req_wr && (dev_now == DEV_LED || dev_now == DEV_SW)
                         && rd_bit_now;
            end
        end
    end

    // Outputs.
    always_comb begin
        rsp_done  = 1'b0;
        rsp_rdata = '0;
        rom_sel   = 1'b0;
        uart_sel  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOCAL: begin
                rsp_done  = 1'b1;
                rsp_rdata = {31'b0, bit_q};
            end
            ST_EXT: begin
                rom_sel  = (dev_q == DEV_ROM);
                uart_sel = (dev_q == DEV_UART);
                if (rom_sel && rom_done) begin
                    rsp_done  = 1'b1;
                    rsp_rdata = rom_rdata;
                end else if (uart_sel && uart_done) begin
                    rsp_done  = 1'b1;
                    rsp_rdata = uart_rdata;
                end
            end
            default: ;
        endcase
    end

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!rsp_done && !rom_sel && !uart_sel));

    p_local_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !to_ext) |=> rsp_done);

    p_one_sel_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_sel, uart_sel}));

    p_rom_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> !req_wr);

    p_ext_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXT && rsp_done) |=> (state_q == ST_IDLE));

endmodule

// File: tb/mmio_hub_bench.sv
module mmio_hub_bench;

    typedef struct packed {
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [23:0] sw;
        logic [31:0] exp_rd;
        logic [23:0] exp_led;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'hFFFF0100, 32'h00000001, 24'h000000, 32'h0, 24'h000001}, // R3 led0
        '{1'b1, 32'hFFFF015C, 32'hFFFFFFFF, 24'h000000, 32'h0, 24'h800001}, // R3 led23
        '{1'b0, 32'hFFFF015C, 32'h00000000, 24'h000000, 32'h1, 24'h800001}, // R4
        '{1'b0, 32'hFFFF0114, 32'h00000000, 24'hFFFFFF, 32'h0, 24'h800001}, // R4 led5
        '{1'b1, 32'hFFFF015C, 32'h00000002, 24'h000000, 32'h0, 24'h000001}, // R3 clear
        '{1'b0, 32'hFFFF0000, 32'h00000000, 24'h000001, 32'h1, 24'h000001}, // R5 sw0
        '{1'b0, 32'hFFFF005C, 32'h00000000, 24'h7FFFFF, 32'h0, 24'h000001}, // R5 sw23
        '{1'b0, 32'hFFFF005C, 32'h00000000, 24'h800000, 32'h1, 24'h000001}, // R5 sw23
        '{1'b1, 32'hFFFF000C, 32'h00000001, 24'h000000, 32'h0, 24'h000001}, // R6
        '{1'b0, 32'hFFFF0060, 32'h00000000, 24'hFFFFFF, 32'h0, 24'h000001}, // R7
        '{1'b1, 32'hFFFF0200, 32'h00000000, 24'h000000, 32'h0, 24'h000001}, // R7
        '{1'b0, 32'hFFFF0160, 32'h00000000, 24'hFFFFFF, 32'h0, 24'h000001}  // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 1'b0, req_wr = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic [23:0] sw_in = '0;
    logic [23:0] led_out;
    logic        rom_sel, uart_sel;
    logic        rom_done = 1'b0, uart_done = 1'b0;
    logic [31:0] rom_rdata = '0, uart_rdata = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    mmio_hub u_mmio_hub (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sw_in(sw_in), .led_out(led_out),
        .rom_sel(rom_sel), .rom_done(rom_done), .rom_rdata(rom_rdata),
        .uart_sel(uart_sel), .uart_done(uart_done), .uart_rdata(uart_rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    task automatic local_acc(input vec_t v);
        req_rd    = !v.wr;
        req_wr    = v.wr;
        req_addr  = v.addr;
        req_wdata = v.wdata;
        sw_in     = v.sw;
        @(negedge clk);
        chk(rsp_done == 1'b1, "R2 done after one cycle", 32'(rsp_done), 32'h1);
        chk(rsp_rdata == v.exp_rd, "R4/R5/R7 read data", rsp_rdata, v.exp_rd);
        chk(led_out == v.exp_led, "R3/R6 led state", 32'(led_out), 32'(v.exp_led));
        req_rd = 1'b0;
        req_wr = 1'b0;
        sw_in  = ~v.sw;
        @(negedge clk);
        chk(rsp_done == 1'b0, "R2 done single pulse", 32'(rsp_done), 32'h0);
        chk(rsp_rdata == 32'h0, "R2 data zero without done", rsp_rdata, 32'h0);
    endtask

    task automatic ext_acc(input bit wr, input logic [31:0] a, input bit to_rom,
                           input logic [31:0] rd, input int wait_n);
        req_rd   = !wr;
        req_wr   = wr;
        req_addr = a;
        req_wdata = 32'hA5A5A5A5;
        @(negedge clk);
        for (int i = 0; i < wait_n; i++) begin
            if (to_rom) uart_done = 1'b1; else rom_done = 1'b1;
            #1;
            chk(rom_sel == to_rom, "R8/R9 rom_sel while waiting", 32'(rom_sel), 32'(to_rom));
            chk(uart_sel == !to_rom, "R8/R9 uart_sel while waiting", 32'(uart_sel), 32'(!to_rom));
            chk(rsp_done == 1'b0, "R12 stray done ignored", 32'(rsp_done), 32'h0);
            @(negedge clk);
            uart_done = 1'b0;
            rom_done  = 1'b0;
        end
        if (to_rom) begin
            rom_done = 1'b1; rom_rdata = rd;
        end else begin
            uart_done = 1'b1; uart_rdata = rd;
        end
        #1;
        chk(rsp_done == 1'b1, "R8/R9 done routed", 32'(rsp_done), 32'h1);
        chk(rsp_rdata == rd, "R8/R9 data routed", rsp_rdata, rd);
        @(negedge clk);
        rom_done = 1'b0; uart_done = 1'b0;
        req_rd = 1'b0; req_wr = 1'b0;
        #1;
        chk(!rom_sel && !uart_sel, "R8/R9 select released",
            {30'b0, rom_sel, uart_sel}, 32'h0);
        chk(rsp_done == 1'b0, "R2 external done single pulse", 32'(rsp_done), 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(led_out == 24'h0, "R11 led reset", 32'(led_out), 32'h0);
        chk(rsp_done == 1'b0, "R11 done reset", 32'(rsp_done), 32'h0);
        chk(!rom_sel && !uart_sel, "R11 selects reset", {30'b0, rom_sel, uart_sel}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            local_acc(VEC[k]);
        end

        // R1: outside the window, held for several cycles
        req_rd = 1'b1;
        req_addr = 32'h00001000;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!rsp_done && rsp_rdata == 0 && !rom_sel && !uart_sel,
                "R1 no response outside window",
                {rsp_rdata[28:0], rsp_done, rom_sel, uart_sel}, 32'h0);
        end
        req_rd = 1'b0;
        @(negedge clk);

        // R8 with R12: ROM read, two wait cycles with stray UART done
        ext_acc(1'b0, 32'hFFFFE004, 1'b1, 32'h3C1D0008, 2);
        ext_acc(1'b0, 32'hFFFFFFFC, 1'b1, 32'h00000000, 0);
        // R9 with R12: UART read, then UART write overlapping LED 12
        ext_acc(1'b0, 32'hFFFF0124, 1'b0, 32'h00000041, 1);
        ext_acc(1'b1, 32'hFFFF0130, 1'b0, 32'h00000000, 3);
        chk(led_out == 24'h000001, "R9 UART write leaves LEDs", 32'(led_out), 32'h1);

        // R10: ROM write completes locally
        local_acc('{1'b1, 32'hFFFFE010, 32'h00000001, 24'h0, 32'h0, 24'h000001});
        chk(!rom_sel, "R10 rom never selected", 32'(rom_sel), 32'h0);

        // R11: reset again clears LEDs
        rst_n = 1'b0;
        @(negedge clk);
        chk(led_out == 24'h0, "R11 led cleared by reset", 32'(led_out), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule